// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block keeps wall-clock date and time as packed BCD fields and advances them once for each pulse on a one-second tick input. It holds seconds, minutes, hours, day of month, weekday, month and a two-digit year for the years 2000 to 2099. Every carry is handled in hardware: seconds into minutes, minutes into hours, hours into the date and weekday, the date into the month, and the month into the year. The date rolls over according to the month length and to leap years.

Software reaches the block through a byte-wide register port. A write strobe, an address and write data act on the rising clock edge. Read data is a combinational function of the address. A control byte selects 12-hour or 24-hour presentation of the hours field, stops counting, and requests a software reset. A sticky integrity flag is kept in the top bit of the seconds byte. It is set at reset, on a software reset and on each pulse of an oscillator-fail input. While it is set, software must treat the time as invalid.

Top module: `calendar_core`

## Requirements
- R1: After reset the registers read as follows: control (address 0x0) 0x00, seconds (0x3) 0x80 with the integrity flag set, minutes (0x4) 0x00, hours (0x5) 0x00, date (0x6) 0x01, weekday (0x7) 0x00, month (0x8) 0x01, year (0x9) 0x00.
- R2: A write to the seconds byte stores bits 6:0 as the BCD seconds and bit 7 as the integrity flag, so a write with bit 7 at 0 clears the flag.
- R3: Each tick advances the seconds in BCD (0x09 to 0x10, 0x59 to 0x00 with a carry into the minutes). Counting continues while the integrity flag is set.
- R4: The carries ripple through all fields. From 23:59:59 on date 0x31, month 0x12, year 0x99, one tick gives 00:00:00 on date 0x01, month 0x01, year 0x00.
- R5: The date rolls over to 0x01 after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in the other months. In month 0x02 it rolls over after 0x29 when the year is divisible by 4 (00 included) and after 0x28 otherwise. The month advances with each rollover.
- R6: The weekday (address 0x7, values 0 to 6) advances each time the date advances, and wraps from 6 to 0.
- R7: Control bit 3 set selects 12-hour reading of the hours byte: bits 4:0 hold the BCD hour 01 to 12 and bit 5 is set for PM. Internal hour 00 reads 0x12, 11 reads 0x11, 12 reads 0x32 and 23 reads 0x31.
- R8: In 12-hour mode a write to the hours byte is read as the 12-hour format of R7. For example 0x29 becomes hour 21, 0x12 becomes hour 00 and 0x32 becomes hour 12, each shown in 24-hour mode.
- R9: Control bit 5 set stops counting: ticks leave all time fields unchanged, and control reads back with bit 5 set. Clearing the bit resumes counting.
- R10: Writing control with bit 4 set returns every time field and the integrity flag to their reset values on the next edge and clears the control bits, so control reads 0x00.
- R11: A write to a time field takes effect on the next clock edge. A tick in the same cycle is dropped, so the other fields keep their values.
- R12: A pulse on the oscillator-fail input sets the integrity flag and leaves the seconds count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickSec | input | 1 | One-second tick, one cycle wide |
| oscFail | input | 1 | Oscillator-fail pulse; sets the integrity flag |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (4) | Register byte address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data for regAddr, combinational |

## Verification
Every state change in this block (a write, a tick, an oscillator-fail pulse or a software reset) commits on the rising edge that samples it. Because the read port is combinational, the result can be read once that same edge has passed. The bench drives inputs on the falling edge and holds each strobe for one cycle. For a read, it sets the address on a falling edge, with no write or tick pending, and queues the expected byte. The monitor compares that byte just after the next rising edge, when the state is settled and cannot move.

// File: rtl/calendar_pkg.sv
package calendar_pkg;

  localparam int NUM_FIELDS = 7;
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_SEC   = 3;   // fields follow in order sec..year
  localparam int ADDR_MIN   = 4;
  localparam int CTRL_TWELVE_BIT = 3;
  localparam int CTRL_SWRST_BIT  = 4;
  localparam int CTRL_STOP_BIT   = 5;

  typedef struct packed {
    logic [7:0] year;
    logic [4:0] mon;
    logic [2:0] wday;
    logic [5:0] date;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } calTimeT;

  localparam calTimeT RESET_TIME = '{year: 8'h00, mon: 5'h01, wday: 3'h0,
                                     date: 6'h01, hour: 6'h00, min: 7'h00,
                                     sec: 7'h00};

  typedef struct packed {
    logic                  advance;
    logic                  swReset;
    logic                  flagSet;
    logic [NUM_FIELDS-1:0] fieldWr;
  } calStrobeT;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v == 8'h99) return 8'h00;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcdToBin(input logic [7:0] v);
    return {3'b000, v[7:4]} * 7'd10 + {3'b000, v[3:0]};
  endfunction

  function automatic logic [7:0] binToBcd(input logic [6:0] b);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = b / 7'd10;
    ones = b % 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [7:0] daysInMonth(input logic [4:0] mon, input logic [7:0] year);
    logic [6:0] yBin;
    yBin = bcdToBin(year);
    if (mon == 5'h02) return (yBin[1:0] == 2'b00) ? 8'h29 : 8'h28;
    if (mon == 5'h04 || mon == 5'h06 || mon == 5'h09 || mon == 5'h11) return 8'h30;
    return 8'h31;
  endfunction

  function automatic logic [7:0] hour24To12(input logic [5:0] h);
    logic [6:0] hb;
    logic [6:0] h12;
    logic [7:0] t;
    hb  = bcdToBin({2'b00, h});
    h12 = hb % 7'd12;
    if (h12 == 7'd0) h12 = 7'd12;
    t = binToBcd(h12);
    return {2'b00, (hb >= 7'd12), t[4:0]};
  endfunction

  function automatic logic [5:0] hour12To24(input logic [7:0] d);
    logic [6:0] hb;
    logic [6:0] h;
    logic [7:0] t;
    hb = bcdToBin({3'b000, d[4:0]});
    if (d[5]) h = (hb == 7'd12) ? 7'd12 : hb + 7'd12;
    else      h = (hb == 7'd12) ? 7'd0  : hb;
    t = binToBcd(h);
    return t[5:0];
  endfunction

endpackage

// File: rtl/calendar_ctrl.sv
module calendar_ctrl
  import calendar_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        wrData,
  input  logic              tickSec,
  input  logic              oscFail,
  output calStrobeT         st,
  output logic              twelveMode,
  output logic              stopBit,
  output logic [7:0]        ctrlRd
);

  logic ctrlWr;
  logic [NUM_FIELDS-1:0] fieldWr;

  assign ctrlWr = wrEn && (regAddr == ADDR_W'(ADDR_CTRL));

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fieldDecode
    assign fieldWr[i] = wrEn && (regAddr == ADDR_W'(ADDR_SEC + i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      twelveMode <= 1'b0;
      stopBit    <= 1'b0;
    end else if (ctrlWr) begin
      if (wrData[CTRL_SWRST_BIT]) begin
        twelveMode <= 1'b0;
        stopBit    <= 1'b0;
      end else begin
        twelveMode <= wrData[CTRL_TWELVE_BIT];
        stopBit    <= wrData[CTRL_STOP_BIT];
      end
    end
  end

  always_comb begin
    st.fieldWr = fieldWr;
    st.swReset = ctrlWr && wrData[CTRL_SWRST_BIT];
    st.flagSet = oscFail || st.swReset;
    st.advance = tickSec && !stopBit && !(|fieldWr) && !st.swReset;
  end

  always_comb begin
    ctrlRd = 8'h00;
    ctrlRd[CTRL_TWELVE_BIT] = twelveMode;
    ctrlRd[CTRL_STOP_BIT]   = stopBit;
  end

endmodule

// File: rtl/calendar_datapath.sv
module calendar_datapath
  import calendar_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobeT         st,
  input  logic [7:0]        wrData,
  input  logic              twelveMode,
  input  logic [ADDR_W-1:0] regAddr,
  output calTimeT           timeNow,
  output logic              oscFlag,
  output logic [7:0]        fieldRd
);

  calTimeT    nxt;
  logic       flagNxt;
  logic [7:0] secInc, minInc, hourInc, dateInc, monInc, yearInc, dimBcd;
  logic       secWrap, minWrap, hourWrap, dateWrap, monWrap;

  assign secInc  = bcdInc({1'b0, timeNow.sec});
  assign minInc  = bcdInc({1'b0, timeNow.min});
  assign hourInc = bcdInc({2'b00, timeNow.hour});
  assign dateInc = bcdInc({2'b00, timeNow.date});
  assign monInc  = bcdInc({3'b000, timeNow.mon});
  assign yearInc = bcdInc(timeNow.year);
  assign dimBcd  = daysInMonth(timeNow.mon, timeNow.year);

  assign secWrap  = (timeNow.sec == 7'h59);
  assign minWrap  = (timeNow.min == 7'h59);
  assign hourWrap = (timeNow.hour == 6'h23);
  assign dateWrap = ({2'b00, timeNow.date} == dimBcd);
  assign monWrap  = (timeNow.mon == 5'h12);

  always_comb begin
    nxt = timeNow;
    if (st.swReset) begin
      nxt = RESET_TIME;
    end else if (|st.fieldWr) begin
      if (st.fieldWr[0]) nxt.sec  = wrData[6:0];
      if (st.fieldWr[1]) nxt.min  = wrData[6:0];
      if (st.fieldWr[2]) nxt.hour = twelveMode ? hour12To24(wrData) : wrData[5:0];
      if (st.fieldWr[3]) nxt.date = wrData[5:0];
      if (st.fieldWr[4]) nxt.wday = wrData[2:0];
      if (st.fieldWr[5]) nxt.mon  = wrData[4:0];
      if (st.fieldWr[6]) nxt.year = wrData;
    end else if (st.advance) begin
      nxt.sec = secWrap ? 7'h00 : secInc[6:0];
      if (secWrap) begin
        nxt.min = minWrap ? 7'h00 : minInc[6:0];
        if (minWrap) begin
          nxt.hour = hourWrap ? 6'h00 : hourInc[5:0];
          if (hourWrap) begin
            nxt.wday = (timeNow.wday == 3'd6) ? 3'd0 : timeNow.wday + 3'd1;
            nxt.date = dateWrap ? 6'h01 : dateInc[5:0];
            if (dateWrap) begin
              nxt.mon = monWrap ? 5'h01 : monInc[4:0];
              if (monWrap) nxt.year = yearInc;
            end
          end
        end
      end
    end
  end

  always_comb begin
    flagNxt = oscFlag;
    if (st.flagSet)         flagNxt = 1'b1;
    else if (st.fieldWr[0]) flagNxt = wrData[7];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeNow <= RESET_TIME;
      oscFlag <= 1'b1;
    end else begin
      timeNow <= nxt;
      oscFlag <= flagNxt;
    end
  end

  logic [7:0]        rdBytes [NUM_FIELDS];
  logic [ADDR_W-1:0] idx;
  logic              inRange;

  always_comb begin
    rdBytes[0] = {oscFlag, timeNow.sec};
    rdBytes[1] = {1'b0, timeNow.min};
    rdBytes[2] = twelveMode ? hour24To12(timeNow.hour) : {2'b00, timeNow.hour};
    rdBytes[3] = {2'b00, timeNow.date};
    rdBytes[4] = {5'b00000, timeNow.wday};
    rdBytes[5] = {3'b000, timeNow.mon};
    rdBytes[6] = timeNow.year;
  end

  assign idx     = regAddr - ADDR_W'(ADDR_SEC);
  assign inRange = (regAddr >= ADDR_W'(ADDR_SEC)) &&
                   (regAddr < ADDR_W'(ADDR_SEC + NUM_FIELDS));
  assign fieldRd = inRange ? rdBytes[idx[2:0]] : 8'h00;

endmodule

// File: rtl/calendar_core.sv
module calendar_core
  import calendar_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickSec,
  input  logic              oscFail,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData
);

  calStrobeT  st;
  calTimeT    timeNow;
  logic       twelveMode, stopBit, oscFlag;
  logic [7:0] ctrlRd, fieldRd;

  calendar_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .tickSec(tickSec), .oscFail(oscFail), .st(st), .twelveMode(twelveMode),
    .stopBit(stopBit), .ctrlRd(ctrlRd)
  );

  calendar_datapath #(.ADDR_W(ADDR_W)) i_datapath (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData), .twelveMode(twelveMode),
    .regAddr(regAddr), .timeNow(timeNow), .oscFlag(oscFlag), .fieldRd(fieldRd)
  );

  assign rdData = (regAddr == ADDR_W'(ADDR_CTRL)) ? ctrlRd : fieldRd;

endmodule

// File: rtl/calendar_checker.sv
module calendar_checker
  import calendar_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        wrData,
  input logic              oscFail,
  input logic              stopBit,
  input logic              oscFlag,
  input calTimeT           timeNow
);

  p_flag_set_r12: assert property (@(posedge clk) disable iff (!rstN)
    oscFail |=> oscFlag);

  p_flag_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADDR_W'(ADDR_SEC) && !wrData[7] && !oscFail) |=> !oscFlag);

  p_stop_freeze_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stopBit && !wrEn) |=> $stable(timeNow));

  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADDR_W'(ADDR_MIN)) |=> (timeNow.min == $past(wrData[6:0])));

  p_sw_reset_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADDR_W'(ADDR_CTRL) && wrData[CTRL_SWRST_BIT])
      |=> (oscFlag && !stopBit && timeNow == RESET_TIME));

endmodule

bind calendar_core calendar_checker #(.ADDR_W(ADDR_W)) i_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
  .oscFail(oscFail), .stopBit(stopBit), .oscFlag(oscFlag), .timeNow(timeNow)
);

// File: tb/test_calendar_core.sv
module test_calendar_core;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickSec = 1'b0;
  logic       oscFail = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] regAddr = 4'h0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    logic [3:0] addr;
    string      tag;
  } itemT;
  itemT scoreQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  calendar_core i_calendar_core (
    .clk(clk), .rstN(rstN), .tickSec(tickSec), .oscFail(oscFail),
    .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData), .rdData(rdData)
  );

  // Monitor: compares one queued read just after the rising edge
  always @(posedge clk) begin
    #1;
    if (scoreQ.size() > 0) begin
      itemT it;
      it = scoreQ.pop_front();
      checks++;
      if (rdData !== it.exp) begin
        errors++;
        $display("FAIL %s addr %0h: actual %02h expected %02h", it.tag, it.addr, rdData, it.exp);
      end
    end
  end

  task automatic drive(input logic we, input logic [3:0] a, input logic [7:0] d,
                       input logic tk, input logic of);
    @(negedge clk);
    wrEn = we; regAddr = a; wrData = d; tickSec = tk; oscFail = of;
    @(negedge clk);
    wrEn = 1'b0; tickSec = 1'b0; oscFail = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    drive(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic tick();
    drive(1'b0, regAddr, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic expectRd(input logic [3:0] a, input logic [7:0] e, input string tag);
    itemT it;
    @(negedge clk);
    regAddr = a;
    it.exp = e; it.addr = a; it.tag = tag;
    scoreQ.push_back(it);
    @(posedge clk);
    #2;
  endtask

  task automatic dayEnd(input logic [7:0] d, input logic [7:0] m, input logic [7:0] y,
                        input logic [7:0] expD, input logic [7:0] expM, input string tag);
    wr(4'h3, 8'h59); wr(4'h4, 8'h59); wr(4'h5, 8'h23);
    wr(4'h6, d); wr(4'h8, m); wr(4'h9, y);
    tick();
    expectRd(4'h6, expD, tag);
    expectRd(4'h8, expM, tag);
  endtask

  task automatic hour12Read(input logic [7:0] h24, input logic [7:0] e);
    wr(4'h0, 8'h00); wr(4'h5, h24); wr(4'h0, 8'h08);
    expectRd(4'h5, e, "R7 12h read");
  endtask

  task automatic hour12Write(input logic [7:0] h12, input logic [7:0] e);
    wr(4'h0, 8'h08); wr(4'h5, h12); wr(4'h0, 8'h00);
    expectRd(4'h5, e, "R8 12h write");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    expectRd(4'h0, 8'h00, "R1 ctrl");
    expectRd(4'h3, 8'h80, "R1 sec");
    expectRd(4'h4, 8'h00, "R1 min");
    expectRd(4'h5, 8'h00, "R1 hour");
    expectRd(4'h6, 8'h01, "R1 date");
    expectRd(4'h7, 8'h00, "R1 wday");
    expectRd(4'h8, 8'h01, "R1 month");
    expectRd(4'h9, 8'h00, "R1 year");

    // R3 counting continues with flag set
    tick();
    expectRd(4'h3, 8'h81, "R3 tick with flag");
    // R2 write with bit 7 clear clears the flag
    wr(4'h3, 8'h09);
    expectRd(4'h3, 8'h09, "R2 flag clear");
    tick();
    expectRd(4'h3, 8'h10, "R3 bcd digit carry");
    wr(4'h3, 8'h95);
    expectRd(4'h3, 8'h95, "R2 flag set by write");
    wr(4'h3, 8'h10);

    // R12 oscillator fail sets flag, count kept
    drive(1'b0, 4'h3, 8'h00, 1'b0, 1'b1);
    expectRd(4'h3, 8'h90, "R12 osc fail");
    wr(4'h3, 8'h10);
    expectRd(4'h3, 8'h10, "R2 flag clear again");

    // R4 full carry chain, R6 weekday wrap
    wr(4'h3, 8'h59); wr(4'h4, 8'h59); wr(4'h5, 8'h23); wr(4'h6, 8'h31);
    wr(4'h7, 8'h06); wr(4'h8, 8'h12); wr(4'h9, 8'h99);
    tick();
    expectRd(4'h3, 8'h00, "R4 sec");
    expectRd(4'h4, 8'h00, "R4 min");
    expectRd(4'h5, 8'h00, "R4 hour");
    expectRd(4'h6, 8'h01, "R4 date");
    expectRd(4'h7, 8'h00, "R6 wday wrap");
    expectRd(4'h8, 8'h01, "R4 month");
    expectRd(4'h9, 8'h00, "R4 year");

    // R5 month lengths and leap years
    wr(4'h7, 8'h03);
    dayEnd(8'h30, 8'h04, 8'h23, 8'h01, 8'h05, "R5 april");
    expectRd(4'h7, 8'h04, "R6 wday advance");
    dayEnd(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, "R5 feb common");
    dayEnd(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, "R5 feb leap");
    dayEnd(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, "R5 feb29 end");
    dayEnd(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, "R5 year00 leap");
    dayEnd(8'h30, 8'h01, 8'h23, 8'h31, 8'h01, "R5 jan30");
    dayEnd(8'h31, 8'h01, 8'h23, 8'h01, 8'h02, "R5 jan31");
    dayEnd(8'h30, 8'h11, 8'h23, 8'h01, 8'h12, "R5 nov");

    // R7 12-hour reading
    hour12Read(8'h00, 8'h12);
    hour12Read(8'h11, 8'h11);
    hour12Read(8'h12, 8'h32);
    hour12Read(8'h13, 8'h21);
    hour12Read(8'h23, 8'h31);
    expectRd(4'h0, 8'h08, "R7 ctrl readback");

    // R8 12-hour writing
    hour12Write(8'h29, 8'h21);
    hour12Write(8'h12, 8'h00);
    hour12Write(8'h32, 8'h12);

    // R9 stop
    wr(4'h3, 8'h20);
    wr(4'h0, 8'h20);
    tick();
    expectRd(4'h3, 8'h20, "R9 stopped");
    expectRd(4'h0, 8'h20, "R9 ctrl readback");
    wr(4'h0, 8'h00);
    tick();
    expectRd(4'h3, 8'h21, "R9 resumed");

    // R11 write and tick in the same cycle
    wr(4'h3, 8'h20); wr(4'h4, 8'h05);
    drive(1'b1, 4'h4, 8'h42, 1'b1, 1'b0);
    expectRd(4'h4, 8'h42, "R11 write wins");
    expectRd(4'h3, 8'h20, "R11 tick dropped");

    // R10 software reset
    wr(4'h0, 8'h28);
    wr(4'h0, 8'h10);
    expectRd(4'h0, 8'h00, "R10 ctrl");
    expectRd(4'h3, 8'h80, "R10 sec");
    expectRd(4'h4, 8'h00, "R10 min");
    expectRd(4'h5, 8'h00, "R10 hour");
    expectRd(4'h6, 8'h01, "R10 date");
    expectRd(4'h7, 8'h00, "R10 wday");
    expectRd(4'h8, 8'h01, "R10 month");
    expectRd(4'h9, 8'h00, "R10 year");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule